// File: doc/BRIEF.md
# Integer Add and Compare Execution Unit

This unit takes 16-bit instruction words for a 32-bit integer core and carries out the register arithmetic and compare group in a single cycle. It holds sixteen 32-bit general registers and three status bits. T is the single result flag for every compare and for the carry and overflow variants of the add. M and Q are loaded by the two divide-setup operations.

An instruction is presented on `instrWord` together with `instrValid`. On the next rising clock edge the unit updates the register file and flags. For that one cycle it shows the register write on the write-back outputs. Opcodes outside the group leave all state untouched and pulse `illegal`. The operand fields are nnnn in bits 11:8, naming the destination and first operand Rn, and mmmm in bits 7:4, naming the second operand Rm. An 8-bit immediate in bits 7:0 is sign-extended to 32 bits wherever it is used.

Top module: `arith_cmp_unit`

## Requirements
- R1: After reset (`rstN` low), all sixteen registers read as zero, T, M and Q are 0, and `wbEn` and `illegal` are 0.
- R2: Word 0011nnnnmmmm1100 writes Rn+Rm to Rn and leaves T unchanged. The write appears on `wbEn`/`wbIdx`/`wbData` in the cycle after the instruction.
- R3: Word 0111nnnniiiiiiii adds the sign-extended 8-bit immediate to Rn and writes Rn, leaving T unchanged.
- R4: Word 0011nnnnmmmm1110 writes Rn+Rm+T to Rn and loads T with the carry out of bit 31.
- R5: Word 0011nnnnmmmm1111 writes Rn+Rm to Rn and loads T with 1 exactly when the signed sum overflows.
- R6: Words 0011nnnnmmmmcccc with code 0000 (Rn==Rm), 0010 (Rn>=Rm unsigned), 0011 (Rn>=Rm signed), 0110 (Rn>Rm unsigned) or 0111 (Rn>Rm signed) load T with 1 if the test holds, else 0, and write no register.
- R7: Word 10001000iiiiiiii sets T to 1 when R0 equals the sign-extended immediate, else 0.
- R8: Word 0100nnnn00010001 sets T when Rn>=0 as signed data. Word 0100nnnn00010101 sets T when Rn>0 as signed data.
- R9: Word 0010nnnnmmmm1100 sets T when at least one of the four byte lanes of Rn equals the same lane of Rm, else 0.
- R10: Word 0010nnnnmmmm0111 loads Q with bit 31 of Rn, M with bit 31 of Rm, and T with M XOR Q.
- R11: Word 0000000000011001 clears M, Q and T.
- R12: Any other word with `instrValid` high changes no register or flag and drives `illegal` high for exactly the following cycle.
- R13: With `instrValid` low, no register or flag changes and `wbEn` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| instrValid | input | 1 | Instruction word is valid this cycle |
| instrWord | input | 16 | Instruction word |
| wbEn | output | 1 | A register was written at the last edge |
| wbIdx | output | 4 | Index of the written register |
| wbData | output | 32 | Value written to that register |
| tFlag | output | 1 | T status bit |
| mFlag | output | 1 | M divide-setup bit |
| qFlag | output | 1 | Q divide-setup bit |
| illegal | output | 1 | Previous valid word was not in the group |

## Verification
Every result is due one clock edge after its instruction. This covers the write-back trio, T, M, Q and the `illegal` pulse, since each is a register loaded by that edge. The bench drives a word on a falling edge and samples all outputs on the next falling edge. That places each comparison half a period after the edge that produced it. Register contents that are not written back are brought out later with an add of immediate zero. This is how the checks for unchanged state after illegal words, invalid cycles and reset are made.

// File: rtl/arith_cmp_pkg.sv
package arith_cmp_pkg;

  localparam int IDX_W = 4;
  localparam int IMM_W = 8;

  typedef enum logic [3:0] {
    OP_NOP,
    OP_SUM,
    OP_SUMI,
    OP_SUMC,
    OP_SUMV,
    OP_EQ,
    OP_EQI,
    OP_GEU,
    OP_GES,
    OP_GTU,
    OP_GTS,
    OP_NNEG,
    OP_POS,
    OP_BYTEEQ,
    OP_DSETS,
    OP_DSETU
  } aluOpE;

  typedef struct packed {
    logic             regWr;
    logic             tWr;
    logic             mqWr;
    logic             useImm;
    logic             badOp;
    aluOpE            op;
    logic [IDX_W-1:0] dstIdx;
    logic [IDX_W-1:0] srcIdx;
    logic [IMM_W-1:0] imm8;
  } ctrlStrobeT;

endpackage

// File: rtl/arith_cmp_ctrl.sv
module arith_cmp_ctrl
  import arith_cmp_pkg::*;
(
  input  logic        instrValid,
  input  logic [15:0] instrWord,
  output ctrlStrobeT  strobe
);

  logic [3:0] majorOp;
  logic [3:0] minorOp;

  assign majorOp = instrWord[15:12];
  assign minorOp = instrWord[3:0];

  always_comb begin
    strobe        = '0;
    strobe.op     = OP_NOP;
    strobe.dstIdx = instrWord[11:8];
    strobe.srcIdx = instrWord[7:4];
    strobe.imm8   = instrWord[7:0];
    if (instrValid) begin
      unique case (majorOp)
        4'h3: begin
          unique case (minorOp)
            4'h0: begin strobe.op = OP_EQ;  strobe.tWr = 1'b1; end
            4'h2: begin strobe.op = OP_GEU; strobe.tWr = 1'b1; end
            4'h3: begin strobe.op = OP_GES; strobe.tWr = 1'b1; end
            4'h6: begin strobe.op = OP_GTU; strobe.tWr = 1'b1; end
            4'h7: begin strobe.op = OP_GTS; strobe.tWr = 1'b1; end
            4'hC: begin strobe.op = OP_SUM; strobe.regWr = 1'b1; end
            4'hE: begin
              strobe.op = OP_SUMC; strobe.regWr = 1'b1; strobe.tWr = 1'b1;
            end
            4'hF: begin
              strobe.op = OP_SUMV; strobe.regWr = 1'b1; strobe.tWr = 1'b1;
            end
            default: strobe.badOp = 1'b1;
          endcase
        end
        4'h7: begin
          strobe.op     = OP_SUMI;
          strobe.regWr  = 1'b1;
          strobe.useImm = 1'b1;
        end
        4'h8: begin
          if (instrWord[11:8] == 4'h8) begin
            strobe.op     = OP_EQI;
            strobe.dstIdx = '0;
            strobe.useImm = 1'b1;
            strobe.tWr    = 1'b1;
          end else begin
            strobe.badOp = 1'b1;
          end
        end
        4'h4: begin
          if (instrWord[7:0] == 8'h11) begin
            strobe.op = OP_NNEG; strobe.tWr = 1'b1;
          end else if (instrWord[7:0] == 8'h15) begin
            strobe.op = OP_POS; strobe.tWr = 1'b1;
          end else begin
            strobe.badOp = 1'b1;
          end
        end
        4'h2: begin
          unique case (minorOp)
            4'hC: begin strobe.op = OP_BYTEEQ; strobe.tWr = 1'b1; end
            4'h7: begin
              strobe.op = OP_DSETS; strobe.tWr = 1'b1; strobe.mqWr = 1'b1;
            end
            default: strobe.badOp = 1'b1;
          endcase
        end
        4'h0: begin
          if (instrWord[11:0] == 12'h019) begin
            strobe.op = OP_DSETU; strobe.tWr = 1'b1; strobe.mqWr = 1'b1;
          end else begin
            strobe.badOp = 1'b1;
          end
        end
        default: strobe.badOp = 1'b1;
      endcase
    end
  end

  // R12
  always_comb begin
    decode_excl_chk: assert (!(strobe.badOp && (strobe.regWr || strobe.tWr || strobe.mqWr)));
  end

endmodule

// File: rtl/arith_cmp_dpath.sv
module arith_cmp_dpath
  import arith_cmp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        ctrl,
  output logic              wbEn,
  output logic [IDX_W-1:0]  wbIdx,
  output logic [DATA_W-1:0] wbData,
  output logic              tFlag,
  output logic              mFlag,
  output logic              qFlag,
  output logic              illegal
);

  localparam int REG_CNT = 1 << IDX_W;
  localparam int LANES   = DATA_W / 8;
  localparam int MSB     = DATA_W - 1;

  logic [DATA_W-1:0] regFile [REG_CNT];
  logic [DATA_W-1:0] opA, opB, immExt;
  logic [DATA_W:0]   sumFull;
  logic              carryIn, sumOvf, anyLane;
  logic [LANES-1:0]  laneHit;
  logic              nextT, nextM, nextQ;

  assign immExt  = {{(DATA_W-IMM_W){ctrl.imm8[IMM_W-1]}}, ctrl.imm8};
  assign opA     = regFile[ctrl.dstIdx];
  assign opB     = ctrl.useImm ? immExt : regFile[ctrl.srcIdx];
  assign carryIn = (ctrl.op == OP_SUMC) ? tFlag : 1'b0;
  assign sumFull = {1'b0, opA} + {1'b0, opB} + {{DATA_W{1'b0}}, carryIn};
  assign sumOvf  = (opA[MSB] == opB[MSB]) && (sumFull[MSB] != opA[MSB]);

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    assign laneHit[lane] = (opA[8*lane +: 8] == opB[8*lane +: 8]);
  end
  assign anyLane = |laneHit;

  always_comb begin
    nextT = tFlag;
    nextM = mFlag;
    nextQ = qFlag;
    unique case (ctrl.op)
      OP_SUMC:   nextT = sumFull[DATA_W];
      OP_SUMV:   nextT = sumOvf;
      OP_EQ,
      OP_EQI:    nextT = (opA == opB);
      OP_GEU:    nextT = (opA >= opB);
      OP_GES:    nextT = ($signed(opA) >= $signed(opB));
      OP_GTU:    nextT = (opA > opB);
      OP_GTS:    nextT = ($signed(opA) > $signed(opB));
      OP_NNEG:   nextT = !opA[MSB];
      OP_POS:    nextT = !opA[MSB] && (|opA);
      OP_BYTEEQ: nextT = anyLane;
      OP_DSETS: begin
        nextQ = opA[MSB];
        nextM = opB[MSB];
        nextT = opA[MSB] ^ opB[MSB];
      end
      OP_DSETU: begin
        nextQ = 1'b0;
        nextM = 1'b0;
        nextT = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_CNT; i++) regFile[i] <= '0;
      tFlag   <= 1'b0;
      mFlag   <= 1'b0;
      qFlag   <= 1'b0;
      wbEn    <= 1'b0;
      wbIdx   <= '0;
      wbData  <= '0;
      illegal <= 1'b0;
    end else begin
      wbEn    <= ctrl.regWr;
      illegal <= ctrl.badOp;
      if (ctrl.regWr) begin
        regFile[ctrl.dstIdx] <= sumFull[MSB:0];
        wbIdx                <= ctrl.dstIdx;
        wbData               <= sumFull[MSB:0];
      end
      if (ctrl.tWr) tFlag <= nextT;
      if (ctrl.mqWr) begin
        mFlag <= nextM;
        qFlag <= nextQ;
      end
    end
  end

  // R2
  plain_sum_keeps_t_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.op == OP_SUM) |=> (wbEn && $stable(tFlag)));

  // R6
  compare_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.op inside {OP_EQ, OP_GEU, OP_GES, OP_GTU, OP_GTS}) |=> !wbEn);

  // R10
  signed_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.op == OP_DSETS) |=> (tFlag == (mFlag ^ qFlag)));

  // R11
  unsigned_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.op == OP_DSETU) |=> (!tFlag && !mFlag && !qFlag));

  // R12
  bad_op_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.badOp |=> (illegal && !wbEn && $stable(tFlag) && $stable(mFlag) && $stable(qFlag)));

  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.op == OP_NOP && !ctrl.badOp) |=>
      (!wbEn && !illegal && $stable(tFlag) && $stable(mFlag) && $stable(qFlag)));

endmodule

// File: rtl/arith_cmp_unit.sv
module arith_cmp_unit
  import arith_cmp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [15:0]       instrWord,
  output logic              wbEn,
  output logic [3:0]        wbIdx,
  output logic [DATA_W-1:0] wbData,
  output logic              tFlag,
  output logic              mFlag,
  output logic              qFlag,
  output logic              illegal
);

  ctrlStrobeT strobe;

  arith_cmp_ctrl u_ctrl (
    .instrValid (instrValid),
    .instrWord  (instrWord),
    .strobe     (strobe)
  );

  arith_cmp_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (strobe),
    .wbEn    (wbEn),
    .wbIdx   (wbIdx),
    .wbData  (wbData),
    .tFlag   (tFlag),
    .mFlag   (mFlag),
    .qFlag   (qFlag),
    .illegal (illegal)
  );

endmodule

// File: tb/tb_arith_cmp_unit.sv
module tb_arith_cmp_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [15:0] instrWord = '0;
  logic        wbEn, tFlag, mFlag, qFlag, illegal;
  logic [3:0]  wbIdx;
  logic [31:0] wbData;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  arith_cmp_unit dut (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .wbEn(wbEn), .wbIdx(wbIdx), .wbData(wbData),
    .tFlag(tFlag), .mFlag(mFlag), .qFlag(qFlag), .illegal(illegal)
  );

  // layout: req[64:57] word[56:41] wb[40] idx[39:36] data[35:4] t[3] m[2] q[1] ill[0]
  localparam int NV = 35;
  localparam logic [64:0] VECS [NV] = '{
    {8'd3,  16'h7105, 1'b1, 4'd1, 32'h00000005, 4'b0000}, // R3
    {8'd3,  16'h72FF, 1'b1, 4'd2, 32'hFFFFFFFF, 4'b0000}, // R3 sign extension
    {8'd2,  16'h321C, 1'b1, 4'd2, 32'h00000004, 4'b0000}, // R2
    {8'd3,  16'h73FF, 1'b1, 4'd3, 32'hFFFFFFFF, 4'b0000}, // R3
    {8'd7,  16'h8800, 1'b0, 4'd0, 32'h0,        4'b1000}, // R7
    {8'd2,  16'h321C, 1'b1, 4'd2, 32'h00000009, 4'b1000}, // R2 T kept
    {8'd4,  16'h313E, 1'b1, 4'd1, 32'h00000005, 4'b1000}, // R4 carry in and out
    {8'd11, 16'h0019, 1'b0, 4'd0, 32'h0,        4'b0000}, // R11
    {8'd4,  16'h323E, 1'b1, 4'd2, 32'h00000008, 4'b1000}, // R4
    {8'd5,  16'h321F, 1'b1, 4'd2, 32'h0000000D, 4'b0000}, // R5 no overflow
    {8'd6,  16'h3133, 1'b0, 4'd0, 32'h0,        4'b1000}, // R6 signed ge
    {8'd6,  16'h3132, 1'b0, 4'd0, 32'h0,        4'b0000}, // R6 unsigned ge
    {8'd6,  16'h3316, 1'b0, 4'd0, 32'h0,        4'b1000}, // R6 unsigned gt
    {8'd6,  16'h3317, 1'b0, 4'd0, 32'h0,        4'b0000}, // R6 signed gt
    {8'd6,  16'h3110, 1'b0, 4'd0, 32'h0,        4'b1000}, // R6 equal
    {8'd6,  16'h3116, 1'b0, 4'd0, 32'h0,        4'b0000}, // R6 equal operands, gt
    {8'd6,  16'h3112, 1'b0, 4'd0, 32'h0,        4'b1000}, // R6 equal operands, ge
    {8'd6,  16'h3117, 1'b0, 4'd0, 32'h0,        4'b0000}, // R6
    {8'd6,  16'h3113, 1'b0, 4'd0, 32'h0,        4'b1000}, // R6
    {8'd8,  16'h4011, 1'b0, 4'd0, 32'h0,        4'b1000}, // R8 zero is >= 0
    {8'd8,  16'h4015, 1'b0, 4'd0, 32'h0,        4'b0000}, // R8 zero is not > 0
    {8'd8,  16'h4115, 1'b0, 4'd0, 32'h0,        4'b1000}, // R8
    {8'd8,  16'h4311, 1'b0, 4'd0, 32'h0,        4'b0000}, // R8 negative
    {8'd7,  16'h8805, 1'b0, 4'd0, 32'h0,        4'b0000}, // R7
    {8'd3,  16'h70FD, 1'b1, 4'd0, 32'hFFFFFFFD, 4'b0000}, // R3
    {8'd7,  16'h88FD, 1'b0, 4'd0, 32'h0,        4'b1000}, // R7 negative immediate
    {8'd9,  16'h213C, 1'b0, 4'd0, 32'h0,        4'b0000}, // R9 no lane matches
    {8'd9,  16'h212C, 1'b0, 4'd0, 32'h0,        4'b1000}, // R9 upper lanes match
    {8'd10, 16'h2137, 1'b0, 4'd0, 32'h0,        4'b1100}, // R10 M=1 Q=0
    {8'd10, 16'h2337, 1'b0, 4'd0, 32'h0,        4'b0110}, // R10 M=1 Q=1
    {8'd10, 16'h2317, 1'b0, 4'd0, 32'h0,        4'b1010}, // R10 M=0 Q=1
    {8'd11, 16'h0019, 1'b0, 4'd0, 32'h0,        4'b0000}, // R11
    {8'd6,  16'h3110, 1'b0, 4'd0, 32'h0,        4'b1000}, // R6
    {8'd12, 16'h3111, 1'b0, 4'd0, 32'h0,        4'b1001}, // R12 unknown code
    {8'd12, 16'h7100, 1'b1, 4'd1, 32'h00000005, 4'b1000}  // R12 R1 untouched
  };

  task automatic cmp(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] w, input logic v);
    instrWord  = w;
    instrValid = v;
    @(negedge clk);
    instrValid = 1'b0;
  endtask

  task automatic expectWb(input int req, input logic [3:0] idx, input logic [31:0] data);
    cmp(req, "wbEn", {31'b0, wbEn}, 32'd1);
    cmp(req, "wbIdx", {28'b0, wbIdx}, {28'b0, idx});
    cmp(req, "wbData", wbData, data);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    cmp(1, "wbEn", {31'b0, wbEn}, 0);
    cmp(1, "tFlag", {31'b0, tFlag}, 0);
    cmp(1, "mFlag", {31'b0, mFlag}, 0);
    cmp(1, "qFlag", {31'b0, qFlag}, 0);
    cmp(1, "illegal", {31'b0, illegal}, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [64:0] v;
      int          rq;
      v  = VECS[i];
      rq = int'(v[64:57]);
      issue(v[56:41], 1'b1);
      cmp(rq, "wbEn", {31'b0, wbEn}, {31'b0, v[40]});
      if (v[40]) begin
        cmp(rq, "wbIdx", {28'b0, wbIdx}, {28'b0, v[39:36]});
        cmp(rq, "wbData", wbData, v[35:4]);
      end
      cmp(rq, "tFlag", {31'b0, tFlag}, {31'b0, v[3]});
      cmp(rq, "mFlag", {31'b0, mFlag}, {31'b0, v[2]});
      cmp(rq, "qFlag", {31'b0, qFlag}, {31'b0, v[1]});
      cmp(rq, "illegal", {31'b0, illegal}, {31'b0, v[0]});
    end

    // R13: an add with valid low must not reach R1 or T
    issue(16'h7109, 1'b0);
    cmp(13, "wbEn", {31'b0, wbEn}, 0);
    issue(16'h0019, 1'b0);
    cmp(13, "tFlag", {31'b0, tFlag}, 1);
    issue(16'h7100, 1'b1);
    expectWb(13, 4'd1, 32'h5);

    // R5: build 0x40000000 by doubling, then overflow both ways
    issue(16'h7701, 1'b1);
    for (int k = 0; k < 30; k++) issue(16'h377C, 1'b1);
    expectWb(2, 4'd7, 32'h40000000);
    issue(16'h377F, 1'b1);
    expectWb(5, 4'd7, 32'h80000000);
    cmp(5, "tFlag pos overflow", {31'b0, tFlag}, 1);
    issue(16'h0019, 1'b1);
    issue(16'h377F, 1'b1);
    expectWb(5, 4'd7, 32'h0);
    cmp(5, "tFlag neg overflow", {31'b0, tFlag}, 1);

    // R4: carry out without carry in, then carry-in alone
    issue(16'h0019, 1'b1);
    issue(16'h78FF, 1'b1);
    issue(16'h7901, 1'b1);
    issue(16'h389E, 1'b1);
    expectWb(4, 4'd8, 32'h0);
    cmp(4, "carry out", {31'b0, tFlag}, 1);
    issue(16'h3A9E, 1'b1);
    expectWb(4, 4'd10, 32'h2);
    cmp(4, "carry cleared", {31'b0, tFlag}, 0);

    // R1: reset mid-run clears registers and flags
    issue(16'h3110, 1'b1);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    cmp(1, "tFlag after reset", {31'b0, tFlag}, 0);
    issue(16'h7100, 1'b1);
    expectWb(1, 4'd1, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule